// File: doc/BRIEF.md
# ADC Multi-Channel Scan Sequencer

This block drives a successive-approximation converter through a sweep of input channels. The converter is reached only through a handshake port. The block pulses a start strobe with a channel number and waits for a done pulse carrying a 10-bit sample. A scan always begins at channel 0 and climbs one channel at a time up to a programmed last channel, inclusive. Each sample lands in that channel's own 16-bit result buffer.

Software reaches the block through a byte-wide register bus. One control register holds the power/enable bit, the repeat bit and the alignment bit. A status register holds the scan-complete flag, the interrupt enable and the last-channel field. Writing the status register clears the flag and reloads the last channel in one write. Raising the enable takes two writes: the first powers the converter up, and a second write after the warm-up period starts a scan. In single mode the sweep stops after the last channel. In continuous mode it wraps to channel 0 by itself until the enable is cleared.

Buffers are read as byte pairs. The byte read first latches its partner, so a pair read during an active scan still belongs to one sample.

Top module: `adc_scan_seq`

Register map (bus address, 6 bits):
- `0x00` status. Bit 7 is the scan-complete flag (read-only). Bit 5 is the interrupt enable. Bits 3:0 are the last channel.
- `0x01` control. Bit 0 is enable/power. Bit 1 selects continuous mode. Bit 2 selects right alignment (1) or left alignment (0).
- `0x20 + 2*c` is the high byte of channel c's buffer; `0x21 + 2*c` is its low byte.

## Requirements
- R1: After reset, the status and control registers read 0x00, every buffer byte reads 0, and `irq` and `conv_start` are low.
- R2: Power-up takes two control writes with bit 0 set. The first write only starts a warm-up of WAKE_CYCLES+1 cycles and raises no `conv_start`. A write made during the warm-up is ignored. The first write after the warm-up raises `conv_start` for channel 0 one cycle later.
- R3: A scan converts channels 0, 1, … up to the last channel, in that order, with no channel skipped. After a done pulse that is not for the last channel, the next `conv_start` comes in the following cycle with the channel number raised by one.
- R4: The sample delivered with each done pulse is stored in the buffer of the channel being converted. Other buffers are left unchanged.
- R5: In single mode (control bit 1 = 0), no further `conv_start` occurs after the last channel's sample until a new control write with bit 0 set.
- R6: In continuous mode (control bit 1 = 1), the done pulse of the last channel is followed in the next cycle by `conv_start` for channel 0, without any software write.
- R7: Status bit 7 is set when the last channel's sample is stored. `irq` is high exactly while status bit 7 and status bit 5 are both 1.
- R8: A write to the status register clears bit 7 and loads bit 5 and bits 3:0 from the written byte. Reads of bits 3:0 return the programmed last channel, never the channel currently being converted.
- R9: With right alignment the 10-bit sample fills buffer bits 9:0, so the high byte reads the sample's bits 9:8. With left alignment it fills buffer bits 15:6, so the high byte reads bits 9:2 and the low byte reads bits 1:0 followed by six zeros.
- R10: The first byte of a pair (low byte if right-aligned, high byte if left-aligned) latches the other byte. A following read of that other byte returns the latched value, even if the buffer was rewritten in between.
- R11: A control write with bit 0 = 0 stops the scan at once. It returns control bit 0 to 0, keeps all buffer contents, and requires the two-write start of R2 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe; a first-byte buffer read latches the partner byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| conv_start | output | 1 | One-cycle request to convert `conv_ch` |
| conv_ch | output | 4 | Channel being converted |
| conv_done | input | 1 | One-cycle pulse: `conv_result` is valid |
| conv_result | input | 10 | Converted sample |
| irq | output | 1 | Scan-complete interrupt request |

## Verification
The sweep is tried with a last channel of 3 in single mode, then 1, then 5 during a continuous run. These cases separate a correct inclusive upper bound from an off-by-one, and show that a reload during a scan takes effect without corrupting the channel read back. A converter model returns a different sample for every conversion. Comparing the buffers therefore shows whether a sample went to the wrong channel or a stale one was kept. Buffers are read under both alignments and with the partner byte read after a rescan, which separates live reads from latched ones. Abort is tried in the middle of a continuous run, followed by an early single restart write. This shows that the scan stops, the buffers survive and the warm-up step is required again.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int RES_W       = 10,
  parameter int WAKE_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             conv_start,
  output logic [3:0]       conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             irq
);
  localparam int NCH = 16;
  localparam int PAD = 16 - RES_W;
  localparam int WW  = $clog2(WAKE_CYCLES + 1);

  typedef enum logic [1:0] {P_OFF, P_WARM, P_READY} pow_t;

  pow_t            pow;
  logic [WW-1:0]   wcnt;
  logic            run, cont, ralign, eoc, ie;
  logic [3:0]      cur, last_ch;
  logic [7:0]      shadow;
  logic [RES_W-1:0] buf_q [NCH];

  wire wr_stat  = bus_wr && bus_addr == 6'd0;
  wire wr_ctrl  = bus_wr && bus_addr == 6'd1;
  wire abort    = wr_ctrl && !bus_wdata[0];
  wire is_buf   = bus_addr[5];
  wire lo_sel   = bus_addr[0];
  wire first_rd = (lo_sel == ralign);
  wire unused_wbits = ^{bus_wdata[7:6], bus_wdata[4]};

  logic [15:0] word;
  always_comb begin
    if (ralign) word = {{PAD{1'b0}}, buf_q[bus_addr[4:1]]};
    else        word = {buf_q[bus_addr[4:1]], {PAD{1'b0}}};
  end

  always_comb begin
    if (is_buf)              bus_rdata = first_rd ? (lo_sel ? word[7:0] : word[15:8]) : shadow;
    else if (bus_addr == 6'd0) bus_rdata = {eoc, 1'b0, ie, 1'b0, last_ch};
    else if (bus_addr == 6'd1) bus_rdata = {5'd0, ralign, cont, pow != P_OFF};
    else                     bus_rdata = 8'd0;
  end

  assign conv_ch = cur;
  assign irq     = eoc && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow <= '0;
    else if (bus_rd && is_buf && first_rd) shadow <= lo_sel ? word[15:8] : word[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pow <= P_OFF; wcnt <= '0; run <= 1'b0; cont <= 1'b0; ralign <= 1'b0;
      eoc <= 1'b0; ie <= 1'b0; cur <= '0; last_ch <= '0; conv_start <= 1'b0;
      for (int i = 0; i < NCH; i++) buf_q[i] <= '0;
    end else begin
      conv_start <= 1'b0;
      if (wr_stat) begin
        eoc     <= 1'b0;
        ie      <= bus_wdata[5];
        last_ch <= bus_wdata[3:0];
      end
      if (wr_ctrl) begin
        cont   <= bus_wdata[1];
        ralign <= bus_wdata[2];
      end
      if (abort) begin
        pow <= P_OFF;
        run <= 1'b0;
      end else begin
        if (wr_ctrl && pow == P_OFF) begin
          pow  <= P_WARM;
          wcnt <= WW'(WAKE_CYCLES);
        end else if (pow == P_WARM) begin
          if (wcnt == '0) pow <= P_READY;
          else            wcnt <= wcnt - 1'b1;
        end
        if (wr_ctrl && pow == P_READY && !run) begin
          run <= 1'b1; cur <= '0; conv_start <= 1'b1;
        end else if (run && conv_done) begin
          buf_q[cur] <= conv_result;
          if (cur >= last_ch) begin
            eoc <= 1'b1;
            if (cont) begin cur <= '0; conv_start <= 1'b1; end
            else      run <= 1'b0;
          end else begin
            cur <= cur + 1'b1; conv_start <= 1'b1;
          end
        end
      end
    end
  end

  assert_start_when_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (pow == P_READY && run));

  assert_channel_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && $past(run) && cur != 4'd0) |-> cur == 4'($past(cur) + 1'b1));

  assert_single_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cont && conv_done && cur >= last_ch && !abort) |=> (!run && !conv_start));

  assert_cont_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cont && conv_done && cur >= last_ch && !abort) |=> (conv_start && cur == 4'd0));

  assert_flag_from_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(run && conv_done));

  assert_abort_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!run && !conv_start && pow == P_OFF));
endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int WAKE = 8;
  localparam int LAT  = 4;

  logic clk = 0, rst_n = 0;
  logic [5:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic conv_start, irq;
  logic [3:0] conv_ch;
  logic conv_done = 0;
  logic [9:0] conv_result = 0;

  adc_scan_seq #(.RES_W(10), .WAKE_CYCLES(WAKE)) u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_result(conv_result), .irq(irq));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, done_flag = 0;
  int starts = 0, ch0_starts = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // converter model
  int pch = 0, cnt = 0, nconv = 0;
  always @(negedge clk) begin
    conv_done = 0;
    if (conv_start) begin pch = conv_ch; cnt = LAT; end
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        conv_done = 1;
        conv_result = 10'((pch * 61 + nconv * 13 + 7) % 1024);
        nconv++;
      end
    end
  end

  // behavioural reference model
  int m_pow, m_w, m_run, m_cur, m_last, m_cont, m_ral, m_eoc, m_ie, m_start;
  int m_buf[16];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pow = 0; m_w = 0; m_run = 0; m_cur = 0; m_last = 0; m_cont = 0; m_ral = 0;
      m_eoc = 0; m_ie = 0; m_start = 0;
      foreach (m_buf[i]) m_buf[i] = 0;
    end else begin
      int o_pow, o_w, o_run, o_cur, o_last, o_cont;
      bit ws, wc;
      o_pow = m_pow; o_w = m_w; o_run = m_run; o_cur = m_cur; o_last = m_last; o_cont = m_cont;
      ws = bus_wr && bus_addr == 0;
      wc = bus_wr && bus_addr == 1;
      m_start = 0;
      if (ws) begin m_eoc = 0; m_ie = bus_wdata[5]; m_last = bus_wdata[3:0]; end
      if (wc) begin m_cont = bus_wdata[1]; m_ral = bus_wdata[2]; end
      if (wc && !bus_wdata[0]) begin m_pow = 0; m_run = 0; end
      else begin
        if (wc && o_pow == 0) begin m_pow = 1; m_w = WAKE; end
        else if (o_pow == 1) begin if (o_w == 0) m_pow = 2; else m_w = o_w - 1; end
        if (wc && o_pow == 2 && !o_run) begin m_run = 1; m_cur = 0; m_start = 1; end
        else if (o_run && conv_done) begin
          m_buf[o_cur] = conv_result;
          if (o_cur >= o_last) begin
            m_eoc = 1;
            if (o_cont) begin m_cur = 0; m_start = 1; end else m_run = 0;
          end else begin m_cur = o_cur + 1; m_start = 1; end
        end
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) if (rst_n && !done_flag) begin
    chk("R2/R5 conv_start", conv_start, m_start);
    if (m_start) chk("R3 conv_ch", conv_ch, m_cur);
    chk("R7 irq", irq, m_eoc && m_ie);
    if (conv_start) begin starts++; if (conv_ch == 0) ch0_starts++; end
  end

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output int v);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_irq(string req);
    int k = 0;
    while (!irq && k < 2000) begin @(negedge clk); k++; end
    chk(req, irq, 1);
  endtask

  // read a buffer pair in the correct order and compare with the model
  task automatic rd_pair(int c, string req);
    int v, w, e16;
    e16 = m_ral ? m_buf[c] : (m_buf[c] << 6);
    if (m_ral) begin
      rd(6'(32 + 2*c + 1), v); chk(req, v, e16 & 255);
      rd(6'(32 + 2*c), w);     chk(req, w, (e16 >> 8) & 255);
    end else begin
      rd(6'(32 + 2*c), v);     chk(req, v, (e16 >> 8) & 255);
      rd(6'(32 + 2*c + 1), w); chk(req, w, e16 & 255);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1; checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, s0, exp_lo, old0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 conv_start", conv_start, 0);
    rd(6'h00, v); chk("R1 status", v, 0);
    rd(6'h01, v); chk("R1 control", v, 0);
    rd(6'h27, v); chk("R1 buffer", v, 0);

    // R2 two-step start, single right-aligned scan of 0..3
    wr(6'h00, 8'h23);
    s0 = starts;
    wr(6'h01, 8'h05);
    rd(6'h01, v); chk("R2 enable readback", v, 5);
    wr(6'h01, 8'h05);                 // during warm-up: ignored
    repeat (WAKE + 4) @(negedge clk);
    chk("R2 no start before second write", starts - s0, 0);
    s0 = starts;
    wr(6'h01, 8'h05);
    wait_irq("R7 irq after scan");
    chk("R3 four channels converted", starts - s0, 4);
    rd(6'h00, v); chk("R7 R8 status", v, 'hA3);
    for (int c = 0; c < 4; c++) rd_pair(c, "R4 R9 right-aligned buffer");
    rd_pair(4, "R4 untouched buffer");
    s0 = starts;
    repeat (30) @(negedge clk);
    chk("R5 single mode idle", starts - s0, 0);

    // R8 flag clear, R9 left alignment
    wr(6'h00, 8'h21);
    chk("R8 flag cleared", irq, 0);
    rd(6'h00, v); chk("R8 last channel reload", v, 'h21);
    wr(6'h01, 8'h01);
    wait_irq("R7 irq after left scan");
    rd_pair(0, "R9 left-aligned buffer");
    rd_pair(1, "R9 left-aligned buffer");

    // R10 coherent pair across a rescan
    rd(6'h20, v); chk("R10 first byte", v, (m_buf[0] >> 2) & 255);
    exp_lo = (m_buf[0] & 3) << 6;
    old0 = m_buf[0];
    wr(6'h00, 8'h21);
    wr(6'h01, 8'h01);
    wait_irq("R7 irq after rescan");
    chk("R10 buffer changed", (m_buf[0] != old0), 1);
    rd(6'h21, v); chk("R10 latched partner byte", v, exp_lo);

    // R6 continuous, with R8 reload during the run
    wr(6'h00, 8'h23);
    s0 = ch0_starts;
    wr(6'h01, 8'h07);
    wait_irq("R6 first continuous scan");
    wr(6'h00, 8'h25);
    rd(6'h00, v); chk("R8 programmed last not current", v, 'h25);
    chk("R8 flag cleared in run", irq, 0);
    wait_irq("R6 automatic rescan");
    chk("R6 channel 0 restarted", (ch0_starts - s0) >= 2, 1);
    for (int c = 0; c < 6; c++) rd_pair(c, "R4 continuous buffers");

    // R11 abort
    wr(6'h01, 8'h06);
    s0 = starts;
    repeat (40) @(negedge clk);
    chk("R11 no start after abort", starts - s0, 0);
    rd(6'h01, v); chk("R11 enable cleared", v, 6);
    for (int c = 0; c < 6; c++) rd_pair(c, "R11 buffers kept");
    wr(6'h01, 8'h07);
    repeat (5) @(negedge clk);
    chk("R11 single write only wakes", starts - s0, 0);
    repeat (WAKE) @(negedge clk);
    wr(6'h01, 8'h05);
    repeat (3) @(negedge clk);
    chk("R11 restart after warm-up", (starts - s0) > 0, 1);
    wr(6'h01, 8'h00);
    repeat (10) @(negedge clk);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule